// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed 8-bit integers on an N by N grid of identical multiply-accumulate cells. Each cell owns one element of the result and holds it in a local accumulator. Left-matrix operands move rightward along the rows of the grid and right-matrix operands move downward along its columns. Each cell exchanges data only with its direct neighbours, and only the cells on the left and top edges receive external data.

A caller pulses `start` and then, on the next N clock edges, presents one column of the left matrix and one row of the right matrix on two lane buses. The block adds the staggering itself: row lane i and column lane j are delayed by i and j cycles. The matching pair for result element (r, c) at inner index k therefore meets in cell (r, c) on a diagonal wavefront that moves one anti-diagonal per cycle. When the wavefront has left the bottom-right cell, `done` rises. Any result element can then be read combinationally by row and column index, one per cycle, until the next `start`.

Top module: `sys_matmul`

## Requirements
- R1: After reset, `done` is low and every result element read through `rd_row`/`rd_col` is zero.
- R2: Call the edge that samples `start` high edge S. On edges S+1 through S+N (k = 0..N-1 in order), lane i of `a_row` (bits i*8+7 down to i*8) carries A[i][k] and lane j of `b_col` (bits j*8+7 down to j*8) carries B[k][j], both as 8-bit two's complement. After `done`, element (r, c) reads as the sum over k of A[r][k]*B[k][c].
- R3: Each accumulator is 2*8+clog2(N) bits wide, so any N products of extreme operands (for example all -128, giving +65536 for N=4) are exact.
- R4: `done` is low after edges S through S+3N-3 and rises on edge S+3N-2.
- R5: Bus values outside the N-edge operand window have no effect on any result.
- R6: `start` clears all accumulators and `done` on the edge that samples it. A `start` during a computation abandons that computation, and the new product is exact.
- R7: `rd_data` shows the accumulator selected by `rd_row` and `rd_col` (0..N-1) in the same cycle, with no clock edge in between.
- R8: Once `done` is high, it and every result element stay unchanged until the next `start`, whatever the operand buses carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by every cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that clears the grid and begins a product |
| a_row | input | N*8 | Left-matrix lanes, one 8-bit signed value per row |
| b_col | input | N*8 | Right-matrix lanes, one 8-bit signed value per column |
| done | output | 1 | High once every result element is final |
| rd_row | input | clog2(N) | Row index of the element to read |
| rd_col | input | clog2(N) | Column index of the element to read |
| rd_data | output | 2*8+clog2(N) | Selected result element, signed |

## Verification
An identity right matrix makes the result a copy of the left matrix, so any lane swap, transposition or off-by-one skew shows up as misplaced values. A pair of matrices with one non-zero entry each produces exactly one non-zero result. That result lands in the wrong cell, or is lost, if the wavefront misaligns the inner index k. Random signed matrices check sign handling across all products, and all-extreme operands check that the accumulator is wide enough. Random data driven on the buses outside the window, together with restarts in the middle of a run and back-to-back runs, separates correct gating and clearing from leftover state.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_HOLD} phase_t;

  // accumulator bits: full product plus head-room for n additions
  function automatic int acc_bits(input int w, input int n);
    return 2 * w + $clog2(n);
  endfunction

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // counter value during the final multiply-accumulate of the grid
  function automatic int last_step(input int n);
    return 3 * n - 3;
  endfunction

endpackage

// File: rtl/mm_ctrl.sv
`timescale 1ns/1ps
module mm_ctrl #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic feed_win,
  output logic last_mac
);
  import mm_pkg::*;

  localparam int CNT_W = $clog2(3 * N) + 1;
  localparam int LAST  = last_step(N);

  phase_t             phase;
  logic [CNT_W-1:0]   step;

  assign busy     = (phase == PH_RUN);
  assign done     = (phase == PH_HOLD);
  assign feed_win = busy && (step < CNT_W'(N));
  assign last_mac = busy && (step == CNT_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= '0;
    end else if (start) begin
      phase <= PH_RUN;
      step  <= '0;
    end else if (busy) begin
      if (last_mac) phase <= PH_HOLD;
      step <= step + 1'b1;
    end
  end

endmodule

// File: rtl/mm_skew.sv
`timescale 1ns/1ps
module mm_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  logic signed [W-1:0] sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) sr[s] <= '0;
    end else if (clr) begin
      for (int s = 0; s < DEPTH; s++) sr[s] <= '0;
    end else begin
      sr[0] <= din;
      for (int s = 1; s < DEPTH; s++) sr[s] <= sr[s-1];
    end
  end

  assign dout = sr[DEPTH-1];

endmodule

// File: rtl/mm_cell.sv
`timescale 1ns/1ps
module mm_cell #(
  parameter int W     = 8,
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [W-1:0]     a_in,
  input  logic signed [W-1:0]     b_in,
  output logic signed [ACC_W-1:0] acc
);

  function automatic logic signed [ACC_W-1:0] mac(
    input logic signed [ACC_W-1:0] s,
    input logic signed [W-1:0]     x,
    input logic signed [W-1:0]     y
  );
    logic signed [2*W-1:0] p;
    p = x * y;
    return s + {{(ACC_W - 2 * W){p[2*W-1]}}, p};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= mac(acc, a_in, b_in);
  end

endmodule

// File: rtl/sys_matmul.sv
`timescale 1ns/1ps
module sys_matmul #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       start,
  input  logic [N*W-1:0]                             a_row,
  input  logic [N*W-1:0]                             b_col,
  output logic                                       done,
  input  logic [mm_pkg::idx_bits(N)-1:0]             rd_row,
  input  logic [mm_pkg::idx_bits(N)-1:0]             rd_col,
  output logic signed [mm_pkg::acc_bits(W, N)-1:0]   rd_data
);
  import mm_pkg::*;

  localparam int ACC_W = acc_bits(W, N);

  // named control events, also seen by the bound checker
  logic busy, feed_win, last_mac;

  logic signed [W-1:0]     a_lane [N];
  logic signed [W-1:0]     b_lane [N];
  logic signed [W-1:0]     a_sk   [N];
  logic signed [W-1:0]     b_sk   [N];
  logic signed [W-1:0]     a_p    [N][N-1];
  logic signed [W-1:0]     b_p    [N-1][N];
  logic signed [ACC_W-1:0] acc_a  [N][N];
  logic [N*N*ACC_W-1:0]    acc_flat;

  mm_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .feed_win (feed_win),
    .last_mac (last_mac)
  );

  // zero the edge inputs outside the operand window
  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_lane[i] = feed_win ? a_row[i*W +: W] : '0;
      b_lane[i] = feed_win ? b_col[i*W +: W] : '0;
    end
  end

  // lane i is staggered by i cycles
  for (genvar i = 0; i < N; i++) begin : g_skew
    if (i == 0) begin : g_direct
      assign a_sk[i] = a_lane[i];
      assign b_sk[i] = b_lane[i];
    end else begin : g_delay
      logic signed [W-1:0] a_d, b_d;
      mm_skew #(.W(W), .DEPTH(i)) u_a_skew (
        .clk(clk), .rst_n(rst_n), .clr(start), .din(a_lane[i]), .dout(a_d)
      );
      mm_skew #(.W(W), .DEPTH(i)) u_b_skew (
        .clk(clk), .rst_n(rst_n), .clr(start), .din(b_lane[i]), .dout(b_d)
      );
      assign a_sk[i] = a_d;
      assign b_sk[i] = b_d;
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [W-1:0]     a_in_w, b_in_w;
      logic signed [ACC_W-1:0] acc_w;

      if (c == 0) begin : g_a_edge
        assign a_in_w = a_sk[r];
      end else begin : g_a_nb
        assign a_in_w = a_p[r][c-1];
      end

      if (r == 0) begin : g_b_edge
        assign b_in_w = b_sk[c];
      end else begin : g_b_nb
        assign b_in_w = b_p[r-1][c];
      end

      mm_cell #(.W(W), .ACC_W(ACC_W)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (busy),
        .a_in  (a_in_w),
        .b_in  (b_in_w),
        .acc   (acc_w)
      );

      // operand pipeline register toward the right neighbour
      if (c < N - 1) begin : g_pass_a
        logic signed [W-1:0] a_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     a_q <= '0;
          else if (start) a_q <= '0;
          else            a_q <= a_in_w;
        end
        assign a_p[r][c] = a_q;
      end

      // operand pipeline register toward the cell below
      if (r < N - 1) begin : g_pass_b
        logic signed [W-1:0] b_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     b_q <= '0;
          else if (start) b_q <= '0;
          else            b_q <= b_in_w;
        end
        assign b_p[r][c] = b_q;
      end

      assign acc_a[r][c] = acc_w;
      assign acc_flat[(r*N + c)*ACC_W +: ACC_W] = acc_w;
    end
  end

  assign rd_data = acc_a[rd_row][rd_col];

endmodule

// File: rtl/mm_checker.sv
`timescale 1ns/1ps
module mm_checker #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int ACC_W = 18
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic                   feed_win,
  input logic                   last_mac,
  input logic [N*N*ACC_W-1:0]   acc_flat
);

  localparam int SW = $clog2(3 * N) + 2;
  localparam int WW = $clog2(N) + 2;
  localparam logic [SW-1:0] S_MAX = '1;

  logic [SW-1:0] since;
  logic [WW-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since   <= '0;
      win_cnt <= '0;
    end else if (start) begin
      since   <= '0;
      win_cnt <= '0;
    end else begin
      if (since != S_MAX) since <= since + 1'b1;
      if (feed_win)       win_cnt <= win_cnt + 1'b1;
    end
  end

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_flat == '0) && !done)
    else $error("start did not clear the grid");

  p_window_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feed_win |-> (win_cnt < WW'(N)))
    else $error("operand window longer than N cycles");

  p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (since == SW'(3 * N - 2)))
    else $error("done rose at the wrong step");

  p_last_mac_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_mac && !start |=> done)
    else $error("done missing after final accumulate");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(acc_flat))
    else $error("results changed while done");

  p_no_feed_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !feed_win)
    else $error("operand window open while done");

endmodule

bind sys_matmul mm_checker #(.N(N), .W(W), .ACC_W(ACC_W)) u_mm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .feed_win (feed_win),
  .last_mac (last_mac),
  .acc_flat (acc_flat)
);

// File: tb/sys_matmul_bench.sv
`timescale 1ns/1ps
module sys_matmul_bench;

  localparam int N     = 4;
  localparam int W     = 8;
  localparam int IW    = $clog2(N);
  localparam int ACC_W = 2 * W + $clog2(N);

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    start;
  logic [N*W-1:0]          a_row;
  logic [N*W-1:0]          b_col;
  logic                    done;
  logic [IW-1:0]           rd_row;
  logic [IW-1:0]           rd_col;
  logic signed [ACC_W-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int ma [N][N];
  int mb [N][N];

  sys_matmul #(.N(N), .W(W)) u_sys_matmul (
    .clk(clk), .rst_n(rst_n), .start(start), .a_row(a_row), .b_col(b_col),
    .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_el(input int r, input int c);
    int s = 0;
    for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][c];
    return s;
  endfunction

  task automatic garbage();
    a_row = {N*W{1'b0}} | $urandom;
    b_col = {N*W{1'b0}} | $urandom;
  endtask

  task automatic read_el(input int r, input int c, output int v);
    rd_row = IW'(r);
    rd_col = IW'(c);
    #1;
    v = int'(rd_data);
  endtask

  task automatic check_all(input string req);
    int v;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        read_el(r, c, v);
        chk(v == expect_el(r, c), req, $sformatf("C[%0d][%0d]", r, c), v, expect_el(r, c));
      end
  endtask

  // start, feed N slices with garbage outside the window (R2, R4, R5, R6)
  task automatic run_product();
    int  v0, v1;
    bit  t_ok = 1'b1;
    int  bad_e = -1;
    @(negedge clk);
    start = 1'b1;
    garbage();
    for (int e = 0; e <= 3 * N - 2; e++) begin
      @(negedge clk);
      start = 1'b0;
      if (e < N) begin
        for (int i = 0; i < N; i++) begin
          a_row[i*W +: W] = W'(ma[i][e]);
          b_col[i*W +: W] = W'(mb[e][i]);
        end
      end else garbage();
      if (e == 0) begin
        read_el(0, 0, v0);
        read_el(N - 1, N - 1, v1);
        chk(v0 == 0 && v1 == 0 && !done, "R6", "cleared after start", v0 + v1, 0);
      end
      if (done != (e == 3 * N - 2) && t_ok) begin
        t_ok  = 1'b0;
        bad_e = e;
      end
    end
    chk(t_ok, "R4", "done timing step", bad_e, -1);
    garbage();
    check_all("R2");
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = int'($urandom_range(0, 255)) - 128;
        mb[i][j] = int'($urandom_range(0, 255)) - 128;
      end
  endtask

  task automatic t_reset();
    int v;
    chk(!done, "R1", "done after reset", int'(done), 0);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        read_el(r, c, v);
        chk(v == 0, "R1", "element after reset", v, 0);
      end
  endtask

  task automatic t_identity();
    fill_random();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) mb[i][j] = (i == j) ? 1 : 0;
    run_product();
  endtask

  task automatic t_single_pair();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 0;
        mb[i][j] = 0;
      end
    ma[N-1][0] = -7;
    mb[0][N-2] = 11;
    run_product();
  endtask

  task automatic t_extremes();
    int v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = -128;
        mb[i][j] = -128;
      end
    run_product();
    read_el(N - 1, 0, v);
    chk(v == 16384 * N, "R3", "all -128 sum", v, 16384 * N);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) ma[i][j] = 127;
    run_product();
    read_el(0, N - 1, v);
    chk(v == -16256 * N, "R3", "127 by -128 sum", v, -16256 * N);
  endtask

  task automatic t_hold();
    fill_random();
    run_product();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      garbage();
    end
    chk(done, "R8", "done held", int'(done), 1);
    check_all("R8");
  endtask

  task automatic t_restart();
    fill_random();
    @(negedge clk);
    start = 1'b1;
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < N; i++) begin
        a_row[i*W +: W] = W'(ma[i][e]);
        b_col[i*W +: W] = W'(mb[e][i]);
      end
    end
    fill_random();
    run_product();
  endtask

  task automatic t_readport();
    int v;
    fill_random();
    run_product();
    @(negedge clk);
    rd_row = IW'(N - 1);
    rd_col = IW'(1);
    #0.5;
    v = int'(rd_data);
    chk(v == expect_el(N - 1, 1), "R7", "same-cycle read", v, expect_el(N - 1, 1));
    rd_row = IW'(2);
    rd_col = IW'(N - 1);
    #0.5;
    v = int'(rd_data);
    chk(v == expect_el(2, N - 1), "R7", "same-cycle read", v, expect_el(2, N - 1));
  endtask

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    a_row  = '0;
    b_col  = '0;
    rd_row = '0;
    rd_col = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_single_pair();
    fill_random();
    run_product();
    t_extremes();
    t_hold();
    t_restart();
    fill_random();
    run_product();
    t_readport();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule